// File: doc/BRIEF.md
# Key Matrix Scanner with Latched Result Bank

This block scans a small key matrix built from three column drive lines and three row sense lines. While scanning is enabled it pulls one column low at a time, in a fixed rotation. The width of each pulse is set by a programmable length input. In the last cycle of each pulse it samples the active-low rows. It then stores one result byte for that column in a ring of twelve internal 8-bit latch registers. Each pulse fills the next slot of the ring.

A processor sees the whole ring through a single data port backed by an internal read pointer. The data output always shows the slot under the pointer. A read strobe moves the pointer to the next slot. A write strobe clears the slot under the pointer and leaves the pointer where it is. A per-row mask removes rows that the board has given to general I/O, so those rows never appear as pressed.

Top module: `keyscan_bank`

## Requirements
- R1: After reset every slot holds 0, both pointers are at slot 0, the scan position is column 0 and all column outputs are high.
- R2: While `scan_en` is low all column outputs stay high and no slot is written. The scan position returns to column 0, so the next enable starts on column 0.
- R3: While `scan_en` is high, exactly one column output is low at a time. The columns are driven in the order 0, 1, 2, 0, and each is held low for `pulse_len`+1 clock cycles.
- R4: In the last cycle of each column pulse, a result byte is written. Bits 2:0 hold the pressed rows, where bit r is 1 when `row_n[r]` is low. Bits 4:3 hold the column index, and bits 7:5 are 0.
- R5: A row whose `row_mask` bit is 1 always reads as not pressed in a result byte, whatever its input level.
- R6: Result bytes fill slots 0 to 11 in rotation, one per column pulse, and the write position wraps from 11 to 0. Older contents are overwritten.
- R7: `acc_rdata` shows the slot under the read pointer. A cycle with `acc_rd` high moves the pointer on by one, wrapping from 11 to 0.
- R8: A cycle with `acc_wr` high clears the slot under the read pointer without moving the pointer. If a result byte lands in that same slot in the same cycle, the result byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Enables scanning |
| pulse_len | input | PW | Column pulse length minus one, in cycles |
| row_mask | input | NROW | 1 = ignore that row |
| row_n | input | NROW | Row sense inputs, low = key closed |
| col_n | output | NCOL | Column drive outputs, low = pulse |
| acc_rd | input | 1 | Read strobe: advance read pointer |
| acc_wr | input | 1 | Write strobe: clear slot under read pointer |
| acc_rdata | output | 8 | Slot under read pointer |

## Verification
The bench builds the block with its defaults: three columns, three rows, twelve slots and an 8-bit pulse length. It drives the rows from a behavioural model of a key matrix that reacts to the column outputs. It runs scans with pulse lengths of 0, 1, 2 and 3, which exercises single-cycle pulses as well as longer ones. A run of fourteen pulses, with the key pattern changed after the twelfth, makes the write-side wrap visible in the slot contents. Reading past slot 11 exposes the read-side wrap.

// File: rtl/keyscan_bank.sv
module keyscan_bank #(
  parameter int NCOL  = 3,
  parameter int NROW  = 3,
  parameter int DEPTH = 12,
  parameter int PW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic [PW-1:0]   pulse_len,
  input  logic [NROW-1:0] row_mask,
  input  logic [NROW-1:0] row_n,
  output logic [NCOL-1:0] col_n,
  input  logic            acc_rd,
  input  logic            acc_wr,
  output logic [7:0]      acc_rdata
);
  localparam int CW  = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int PTW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]  cnt;
  logic [CW-1:0]  col;
  logic [PTW-1:0] wr_ptr, rd_ptr;
  logic [7:0]     bank [DEPTH];
  logic           cap;
  logic [7:0]     entry;

  assign cap       = scan_en && (cnt >= pulse_len);
  assign entry     = 8'({col, ~row_n & ~row_mask});
  assign col_n     = scan_en ? ~(NCOL'(1) << col) : '1;
  assign acc_rdata = bank[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      col    <= '0;
      wr_ptr <= '0;
    end else if (!scan_en) begin
      cnt <= '0;
      col <= '0;
    end else if (cap) begin
      cnt    <= '0;
      col    <= (col == CW'(NCOL-1)) ? '0 : col + 1'b1;
      wr_ptr <= (wr_ptr == PTW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_ptr <= '0;
    else if (acc_rd)
      rd_ptr <= (rd_ptr == PTW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cap && wr_ptr == PTW'(i))
          bank[i] <= entry;
        else if (acc_wr && rd_ptr == PTW'(i))
          bank[i] <= '0;
      end
    end
  end

  a_r3_one_column: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~col_n));

  a_r3_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !cap) |=> (!scan_en || $stable(col_n)));

  a_r6_wr_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr < PTW'(DEPTH));

  a_r7_rd_advance: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_ptr == (($past(rd_ptr) == PTW'(DEPTH-1)) ? '0 : $past(rd_ptr) + 1'b1));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !acc_rd && !(cap && wr_ptr == rd_ptr)) |=> acc_rdata == 8'd0);

  a_r2_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !acc_wr) |=> $stable(acc_rdata) || $past(acc_rd));
endmodule

// File: tb/tb_keyscan_bank.sv
module tb_keyscan_bank;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       scan_en = 0;
  logic [7:0] pulse_len = 0;
  logic [2:0] row_mask = 0;
  logic [2:0] row_n;
  logic [2:0] col_n;
  logic       acc_rd = 0, acc_wr = 0;
  logic [7:0] acc_rdata;
  logic [8:0] keys = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  keyscan_bank dut (.clk, .rst_n, .scan_en, .pulse_len, .row_mask, .row_n,
                    .col_n, .acc_rd, .acc_wr, .acc_rdata);

  always_comb
    for (int r = 0; r < 3; r++) begin
      row_n[r] = 1'b1;
      for (int c = 0; c < 3; c++)
        if (!col_n[c] && keys[c*3+r]) row_n[r] = 1'b0;
    end

  // vector: keys[19:11], mask[10:8], pulse_len[7:0]
  localparam logic [19:0] VEC [4] = '{
    {9'b000_000_000, 3'b000, 8'd3},
    {9'b100_010_001, 3'b000, 8'd0},
    {9'b111_101_011, 3'b010, 8'd2},
    {9'b111_111_111, 3'b111, 8'd1}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    scan_en = 0; acc_rd = 0; acc_wr = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    scan_en = 1;
    repeat (n * (int'(pulse_len) + 1)) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string req);
    chk(acc_rdata, exp, req);
    acc_rd = 1;
    @(negedge clk);
    acc_rd = 0;
  endtask

  function automatic logic [7:0] expect_entry(input int c, input logic [8:0] k, input logic [2:0] m);
    return {3'b000, 2'(c), k[c*3+:3] & ~m};
  endfunction

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk(acc_rdata, 8'h00, "R1 slot zero");
    chk({5'b0, col_n}, 8'h07, "R1 columns high");

    foreach (VEC[v]) begin
      do_reset();
      keys = VEC[v][19:11]; row_mask = VEC[v][10:8]; pulse_len = VEC[v][7:0];
      run(3);
      scan_en = 0;
      @(negedge clk);
      chk({5'b0, col_n}, 8'h07, "R2 idle columns");
      for (int c = 0; c < 3; c++)
        rd_chk(expect_entry(c, keys, row_mask), "R4 R5 entry");
    end

    // R3 pulse width and order, pulse_len 3
    do_reset();
    keys = 0; row_mask = 0; pulse_len = 3;
    scan_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({5'b0, col_n}, 8'h06, "R3 col0 held");
    @(negedge clk);
    chk({5'b0, col_n}, 8'h05, "R3 col1 next");
    repeat (4) @(negedge clk);
    chk({5'b0, col_n}, 8'h03, "R3 col2 next");
    scan_en = 0;
    @(negedge clk);
    scan_en = 1;
    #1;
    chk({5'b0, col_n}, 8'h06, "R2 restart col0");
    scan_en = 0;

    // R6 write wrap, R7 read wrap, R8 clear
    do_reset();
    keys = 0; row_mask = 0; pulse_len = 1;
    run(12);
    keys = 9'h1FF;
    run(2);
    scan_en = 0;
    @(negedge clk);
    rd_chk(8'h07, "R6 slot0 overwritten");
    rd_chk(8'h0F, "R6 slot1 overwritten");
    rd_chk(8'h10, "R6 slot2 kept");
    for (int i = 3; i < 12; i++)
      rd_chk(expect_entry(i % 3, 9'h000, 3'b000), "R7 sequential read");
    rd_chk(8'h07, "R7 read wrap to slot0");
    chk(acc_rdata, 8'h0F, "R7 slot1 after wrap");
    acc_wr = 1;
    @(negedge clk);
    acc_wr = 0;
    chk(acc_rdata, 8'h00, "R8 slot cleared");
    rd_chk(8'h00, "R8 pointer unmoved");
    chk(acc_rdata, 8'h10, "R8 neighbour intact");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule